// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit host bus reach a bank of 16-bit internal controller registers. It does so through two host-visible words: a command word and a data word. The internal registers cannot be addressed from the host directly.

To write an internal register, the host first places the value in the data word. It then writes the command word with the internal address and the write flag set. To read, the host writes the command word with the flag clear and reads the data word once the access has finished. Every internal access is slow. After each accepted command, a busy status stays high for `ACCESS_CYCLES` clocks. At the default of 100 cycles and a 200 MHz clock, this is about 500 ns. While busy is high, the bridge ignores host writes to either word.

The register file also holds the 48-bit station address across three consecutive registers. The assembled address is driven out for the MAC logic around the bridge. The host side is a plain single-cycle strobe interface with no back-pressure: every host write is either taken in the cycle it is presented or dropped, and the busy pin tells software which case applies. Host reads are combinational, and they have no side effects.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset, busy is low, both host words read zero, every internal register reads zero and the station address output is zero.
- R2: A host write to the data word (host_sel = 0) while idle stores bits 15:0. Reading the data word returns those bits in 15:0 with bits 31:16 zero, and the upper bits written are ignored.
- R3: A host write to the command word (host_sel = 1) while idle latches the internal address from bits ADDR_W-1:0 and the write flag from bit 15. Busy goes high on the next cycle and stays high for exactly ACCESS_CYCLES cycles.
- R4: When a command with the write flag set finishes, the addressed internal register takes the data word's value, and the data word keeps that value.
- R5: When a command with the write flag clear finishes, the data word takes the addressed internal register's value.
- R6: While busy, host writes to either word are ignored. The running access completes with its original address, flag and data.
- R7: An internal address at or above NUM_REGS reads back zero, and a write to it changes no internal register.
- R8: The station address output is formed from registers STA_BASE, STA_BASE+1 and STA_BASE+2, in that order from most significant. Each register supplies its high byte before its low byte, so octet 0 is bits 47:40 and octet 5 is bits 7:0.
- R9: Reading the command word returns busy in bit 31, the latched write flag in bit 15, the latched address in bits ADDR_W-1:0, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = host write, 0 = host read |
| host_sel | input | 1 | 0 = data word, 1 = command word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected host word, combinational |
| busy | output | 1 | Internal access in progress |
| station_addr | output | 48 | Assembled station address, octet 0 in the top byte |

## Verification
The bench builds the bridge with ACCESS_CYCLES = 6, NUM_REGS = 12, STA_BASE = 3 and ADDR_W = 8. The short access window lets several hundred random commands run. Each command's busy length is counted exactly, so an off-by-one in the countdown shows up. With twelve registers, the last implemented address (11) and the first missing one (12) are both reached, along with far addresses such as 200. Random addresses up to 15 mix implemented and unimplemented targets. With the station registers at 3..5, writes to the neighbouring registers 2 and 6 can be seen to leave the assembled address alone.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_W      = 32;
  localparam int REG_W       = 16;
  localparam int WR_FLAG_BIT = 15;
  localparam int BUSY_BIT    = 31;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CMD  = 1'b1
  } host_sel_e;
endpackage

// File: rtl/ibr_access_seq.sv
module ibr_access_seq #(
  parameter int ACCESS_CYCLES = 100,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr_in,
  input  logic              cmd_wr_in,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_wr,
  output logic [DATA_W-1:0] data_port,
  output logic              acc_write
);
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             finish;

  assign busy      = (cnt != '0);
  assign finish    = (cnt == CNT_LAST);
  assign accept    = cmd_we && !busy;
  assign acc_write = finish && cur_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_addr <= '0;
      cur_wr   <= 1'b0;
    end else if (accept) begin
      cnt      <= CNT_LOAD;
      cur_addr <= cmd_addr_in;
      cur_wr   <= cmd_wr_in;
    end else if (busy) begin
      cnt <= cnt - CNT_LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_port <= '0;
    end else if (finish && !cur_wr) begin
      data_port <= rd_data;
    end else if (data_we && !busy) begin
      data_port <= data_in;
    end
  end

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt == CNT_LOAD)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LOAD); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cur_addr) && $stable(cur_wr))); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(data_port)); // R6
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |=> $stable(data_port)); // R4
endmodule

// File: rtl/ibr_regfile.sv
module ibr_regfile #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              wr_hit;

  assign wr_hit = ({1'b0, wr_addr} < LIMIT);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(g)) begin
        regs[g] <= wdata;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(g)) |=> (regs[g] == $past(wdata))); // R4
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rdata = regs[i];
    end
  end

  AST_UNIMPL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(regs_flat)); // R7
endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge #(
  parameter int ACCESS_CYCLES = 100,
  parameter int NUM_REGS      = 16,
  parameter int STA_BASE      = 0,
  parameter int ADDR_W        = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_write,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        busy,
  output logic [47:0] station_addr
);
  import ibr_pkg::*;

  localparam int FLAT_W = NUM_REGS * REG_W;

  host_sel_e          sel;
  logic               cmd_we;
  logic               data_we;
  logic [ADDR_W-1:0]  cur_addr;
  logic               cur_wr;
  logic [REG_W-1:0]   data_port;
  logic               acc_write;
  logic [REG_W-1:0]   rd_data;
  logic [FLAT_W-1:0]  regs_flat;
  logic [HOST_W-1:0]  cmd_view;
  logic               unused_bits;

  assign sel     = host_sel_e'(host_sel);
  assign cmd_we  = host_req && host_write && (sel == SEL_CMD);
  assign data_we = host_req && host_write && (sel == SEL_DATA);

  ibr_access_seq #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .ADDR_W        (ADDR_W),
    .DATA_W        (REG_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_addr_in (host_wdata[ADDR_W-1:0]),
    .cmd_wr_in   (host_wdata[WR_FLAG_BIT]),
    .data_we     (data_we),
    .data_in     (host_wdata[REG_W-1:0]),
    .rd_data     (rd_data),
    .busy        (busy),
    .cur_addr    (cur_addr),
    .cur_wr      (cur_wr),
    .data_port   (data_port),
    .acc_write   (acc_write)
  );

  ibr_regfile #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (REG_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (acc_write),
    .wr_addr   (cur_addr),
    .wdata     (data_port),
    .rd_addr   (cur_addr),
    .rdata     (rd_data),
    .regs_flat (regs_flat)
  );

  assign station_addr = {regs_flat[STA_BASE*REG_W +: REG_W],
                         regs_flat[(STA_BASE+1)*REG_W +: REG_W],
                         regs_flat[(STA_BASE+2)*REG_W +: REG_W]};

  always_comb begin
    cmd_view                = '0;
    cmd_view[BUSY_BIT]      = busy;
    cmd_view[WR_FLAG_BIT]   = cur_wr;
    cmd_view[ADDR_W-1:0]    = cur_addr;
  end

  assign host_rdata = (sel == SEL_CMD) ? cmd_view : {{(HOST_W-REG_W){1'b0}}, data_port};

  assign unused_bits = ^{host_wdata[31:16], host_wdata[14:ADDR_W], regs_flat};

  AST_IDLE_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy) |=> (busy && cur_addr == $past(host_wdata[ADDR_W-1:0]))); // R3
  AST_BUSY_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && busy && !acc_write && $past(busy)) |=> (data_port != $past(host_wdata[REG_W-1:0]) || $stable(data_port))); // R6
endmodule

// File: tb/indirect_reg_bridge_bench.sv
module indirect_reg_bridge_bench;
  localparam int NCYC  = 6;
  localparam int NREGS = 12;
  localparam int SBASE = 3;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_write = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy;
  logic [47:0] station_addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NREGS];

  always #2.5 clk = ~clk;

  indirect_reg_bridge #(
    .ACCESS_CYCLES (NCYC),
    .NUM_REGS      (NREGS),
    .STA_BASE      (SBASE),
    .ADDR_W        (AW)
  ) u_indirect_reg_bridge (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_write   (host_write),
    .host_sel     (host_sel),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .busy         (busy),
    .station_addr (station_addr)
  );

  function automatic logic [15:0] exp_reg(input int a);
    return (a < NREGS) ? model[a] : 16'h0;
  endfunction

  function automatic logic [47:0] exp_station();
    return {model[SBASE], model[SBASE+1], model[SBASE+2]};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_write = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_write = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [31:0] v);
    host_sel = sel;
    #0.5;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input int a, input logic wr, input string req);
    int n = 0;
    host_wr(1'b1, {16'h0, wr, 7'h0, 8'(a)});
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == NCYC, "R3", 64'(n), 64'(NCYC));
    if (wr && a < NREGS) model[a] = model[a];
    if (req.len() == 0) begin end
  endtask

  task automatic do_write(input int a, input logic [15:0] v);
    host_wr(1'b0, {16'h0, v});
    run_cmd(a, 1'b1, "R4");
    if (a < NREGS) model[a] = v;
  endtask

  task automatic do_read(input int a, input string req);
    logic [31:0] v;
    run_cmd(a, 1'b0, req);
    peek(1'b0, v);
    check(v == {16'h0, exp_reg(a)}, req, 64'(v), 64'({16'h0, exp_reg(a)}));
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1", 64'(busy), 0);
    check(station_addr == 48'h0, "R1", 64'(station_addr), 0);
    peek(1'b0, v); check(v == 32'h0, "R1", 64'(v), 0);
    peek(1'b1, v); check(v == 32'h0, "R1", 64'(v), 0);
    for (int i = 0; i < NREGS; i++) do_read(i, "R1");

    // R2 data word upper bits ignored
    host_wr(1'b0, 32'hDEAD_1234);
    peek(1'b0, v); check(v == 32'h0000_1234, "R2", 64'(v), 64'h1234);

    // R4 write then R5 read back, data word keeps written value
    do_write(0, 16'hA55A);
    peek(1'b0, v); check(v == 32'h0000_A55A, "R4", 64'(v), 64'hA55A);
    host_wr(1'b0, 32'h0000_0000);
    do_read(0, "R5");

    // R8 station address assembly
    do_write(SBASE,   16'h02A1);
    do_write(SBASE+1, 16'hB3C4);
    do_write(SBASE+2, 16'hD5E6);
    check(station_addr == 48'h02A1_B3C4_D5E6, "R8", 64'(station_addr), 64'h02A1B3C4D5E6);
    do_write(SBASE-1, 16'h1111);
    do_write(SBASE+3, 16'h2222);
    check(station_addr == 48'h02A1_B3C4_D5E6, "R8", 64'(station_addr), 64'h02A1B3C4D5E6);

    // R7 boundaries and far unimplemented addresses
    do_write(NREGS-1, 16'h7E7E);
    do_read(NREGS-1, "R7");
    do_write(NREGS, 16'hBEEF);
    do_read(NREGS, "R7");
    do_write(200, 16'hCAFE);
    do_read(200, "R7");
    for (int i = 0; i < NREGS; i++) do_read(i, "R7");
    check(station_addr == exp_station(), "R7", 64'(station_addr), 64'(exp_station()));

    // R9 command word format; upper host bits other than flag ignored
    host_wr(1'b0, 32'h0000_4321);
    host_wr(1'b1, 32'h7F3A_8005);
    peek(1'b1, v); check(v == 32'h8000_8005, "R9", 64'(v), 64'h80008005);
    wait_idle();
    model[5] = 16'h4321;
    peek(1'b1, v); check(v == 32'h0000_8005, "R9", 64'(v), 64'h00008005);
    check(station_addr == exp_station(), "R8", 64'(station_addr), 64'(exp_station()));

    // R6 writes while busy are ignored
    host_wr(1'b1, 32'h0000_0002);
    @(negedge clk);
    host_wr(1'b1, 32'h0000_8007);
    host_wr(1'b0, 32'h0000_5555);
    wait_idle();
    peek(1'b0, v); check(v == {16'h0, model[2]}, "R6", 64'(v), 64'(model[2]));
    peek(1'b1, v); check(v == 32'h0000_0002, "R6", 64'(v), 64'h2);
    do_read(7, "R6");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int a;
      logic wr;
      logic [15:0] d;
      a  = int'($urandom_range(0, 15));
      wr = 1'($urandom_range(0, 1));
      d  = 16'($urandom);
      if (wr) begin
        do_write(a, d);
        peek(1'b0, v); check(v == {16'h0, d}, "R4", 64'(v), 64'(d));
      end else begin
        do_read(a, (a < NREGS) ? "R5" : "R7");
      end
    end
    check(station_addr == exp_station(), "R8", 64'(station_addr), 64'(exp_station()));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BADB002));
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule